// File: doc/BRIEF.md
# Three-Wire Synthesizer Channel Loader

This block turns a channel number into the two serial words that an external integer-N frequency synthesizer needs. It adds the channel number to a base division ratio, so each step moves the synthesizer by one comparison-frequency step. It then splits the total into a programmable-counter part and a swallow-counter part for a dual-modulus prescaler.

A host raises a request together with a channel number while the block is idle. The block drives a clock line, a data line and a load-enable line. It sends the reference word first and the counter word second, and then reports completion. All pulse widths and spacings on the three lines are whole counts of the system clock. Those counts are derived at elaboration from minimum times given in picoseconds, so a faster system clock only lengthens the count values.

A channel whose ratio cannot be represented is refused. In that case an error pulse replaces the transfer, and the serial lines stay quiet.

Top module: `synth_wire_loader`

## Requirements
- R1: The total ratio is n = BASE_N + channel. With the default prescaler select, N = n / 64 (integer part) and A = n mod 64. For example, channel 0 gives N = 545, A = 24, and channel 40 gives N = 546, A = 0.
- R2: The counter word is 19 bits, sent most significant bit first. Its bits are N (11 bits, bit 18 down to 8), then A (7 bits, bit 7 down to 1), then a control bit of 0 in bit 0.
- R3: The reference word is 19 bits, sent most significant bit first. From bit 18 down it holds: charge-pump select 0, lock-output select 0, phase-polarity 1, the prescaler-select bit PRESC_SW (default 1), the 14-bit reference divider REF_DIV (default 1700) in bits 14..1, and a control bit of 1 in bit 0.
- R4: For each accepted request, the reference word goes out before the counter word.
- R5: For every bit, the data line is set with the clock low and held for HALF cycles. The clock is then high for HALF cycles while data stays unchanged. HALF = ceil(T_DAT_PS / CLK_PS), which is 4 by default. Load enable stays low while bits are being shifted.
- R6: After the 19th bit, the clock and data stay low for EDGE = ceil(T_EDGE_PS / CLK_PS) cycles (6 by default). Load enable is then high for LEW = ceil(T_LE_PS / CLK_PS) cycles (20 by default). A low gap of max(LEW, EDGE) cycles follows before the next word or before completion.
- R7: busy is high from the cycle after acceptance up to and including the last gap cycle of the second word. done is high for exactly the one following cycle, and busy is low in that cycle.
- R8: A request while busy is high is ignored. The serial lines, busy, done and err continue exactly as for the transfer in progress.
- R9: If N < 3, N > 2047 or A >= N, the request is refused. err is high for the one cycle after the request, busy stays low and no serial line toggles.
- R10: While reset is asserted, busy, done, err, ser_clk, ser_data and ser_le are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a transfer for req_chan (taken only when idle) |
| req_chan | input | CH_W | Channel number added to the base ratio |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse after the second word is loaded |
| err | output | 1 | One-cycle pulse when a channel is refused |
| ser_clk | output | 1 | Serial clock to the synthesizer |
| ser_data | output | 1 | Serial data, most significant bit first |
| ser_le | output | 1 | Load-enable pulse after each 19-bit word |

## Verification
Two functions can fall in the same cycle: the completion pulse of one transfer and the acceptance of the next request. The bench provokes this by holding req_valid high over several transfers. Each new transfer must then begin in the cycle right after done, with nothing lost or doubled. A behavioural model in the bench holds the expected state of all six outputs for every cycle. The model accepts a request only in a cycle where it expects busy to be low, so the done-cycle acceptance and the ignored mid-transfer request are both judged cycle by cycle. Each word that is clocked out is also decoded and compared against the ratio split computed in the bench.

// File: rtl/swl_pkg.sv
`timescale 1ns/1ps
package swl_pkg;

   localparam int WORD_W = 19;

   typedef enum logic [2:0] {
      S_IDLE,
      S_LO,
      S_HI,
      S_PRE,
      S_LE,
      S_GAP
   } seq_state_t;

   // Whole clock counts covering a minimum time, never below one.
   function automatic int ceil_cnt(input int t_ps, input int clk_ps);
      int c;
      c = (t_ps + clk_ps - 1) / clk_ps;
      return (c < 1) ? 1 : c;
   endfunction

endpackage

// File: rtl/swl_ratio_split.sv
`timescale 1ns/1ps
module swl_ratio_split #(
   parameter int CH_W   = 8,
   parameter int BASE_N = 34904,
   parameter bit SW     = 1'b1
) (
   input  logic [CH_W-1:0] chan,
   output logic [10:0]     n_cnt,
   output logic [6:0]      a_cnt,
   output logic            ok
);
   localparam int NRAW = $clog2(BASE_N + (1 << CH_W)) + 1;
   localparam int NW   = (NRAW < 12) ? 12 : NRAW;

   logic [NW-1:0] n_tot;
   logic [NW-1:0] n_hi;
   logic [6:0]    a_full;

   assign n_tot = NW'(BASE_N) + NW'(chan);

   generate
      if (SW) begin : g_div64
         assign n_hi   = n_tot >> 6;
         assign a_full = {1'b0, n_tot[5:0]};
      end else begin : g_div128
         assign n_hi   = n_tot >> 7;
         assign a_full = n_tot[6:0];
      end
   endgenerate

   assign ok    = (n_hi >= NW'(3)) && (n_hi <= NW'(2047)) && (NW'(a_full) < n_hi);
   assign n_cnt = n_hi[10:0];
   assign a_cnt = a_full;

endmodule

// File: rtl/swl_word_build.sv
`timescale 1ns/1ps
module swl_word_build #(
   parameter int REF_DIV = 1700,
   parameter bit SW      = 1'b1,
   parameter bit CP_SEL  = 1'b0,
   parameter bit LD_SEL  = 1'b0,
   parameter bit PH_SEL  = 1'b1
) (
   input  logic [10:0]                 n_cnt,
   input  logic [6:0]                  a_cnt,
   output logic [swl_pkg::WORD_W-1:0]  ref_word,
   output logic [swl_pkg::WORD_W-1:0]  cnt_word
);
   localparam logic [13:0] RDIV = 14'(REF_DIV);

   // Trailing bit picks the destination latch: 1 reference, 0 counters.
   assign ref_word = {CP_SEL, LD_SEL, PH_SEL, SW, RDIV, 1'b1};
   assign cnt_word = {n_cnt, a_cnt, 1'b0};

endmodule

// File: rtl/swl_serial_seq.sv
`timescale 1ns/1ps
module swl_serial_seq #(
   parameter int HALF_CYC = 4,
   parameter int EDGE_CYC = 6,
   parameter int LE_CYC   = 20,
   parameter int GAP_CYC  = 20
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        start,
   input  logic                        ok,
   input  logic [swl_pkg::WORD_W-1:0]  w_first,
   input  logic [swl_pkg::WORD_W-1:0]  w_second,
   output logic                        busy,
   output logic                        done,
   output logic                        err,
   output logic                        ser_clk,
   output logic                        ser_data,
   output logic                        ser_le
);
   import swl_pkg::*;

   localparam int M1   = (HALF_CYC > EDGE_CYC) ? HALF_CYC : EDGE_CYC;
   localparam int M2   = (LE_CYC > GAP_CYC) ? LE_CYC : GAP_CYC;
   localparam int MAXC = (M1 > M2) ? M1 : M2;
   localparam int CW   = $clog2(MAXC + 1);

   seq_state_t        state;
   logic [CW-1:0]     cnt;
   logic [CW-1:0]     lim;
   logic [4:0]        bit_i;
   logic              second;
   logic [WORD_W-1:0] shreg;
   logic [WORD_W-1:0] pend;

   always_comb begin
      case (state)
         S_LO, S_HI: lim = CW'(HALF_CYC - 1);
         S_PRE:      lim = CW'(EDGE_CYC - 1);
         S_LE:       lim = CW'(LE_CYC - 1);
         S_GAP:      lim = CW'(GAP_CYC - 1);
         default:    lim = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= S_IDLE;
         cnt    <= '0;
         bit_i  <= '0;
         second <= 1'b0;
         shreg  <= '0;
         pend   <= '0;
         done   <= 1'b0;
         err    <= 1'b0;
      end else begin
         done <= 1'b0;
         err  <= 1'b0;
         if (state == S_IDLE) begin
            if (start) begin
               if (ok) begin
                  shreg  <= w_first;
                  pend   <= w_second;
                  second <= 1'b0;
                  bit_i  <= '0;
                  cnt    <= '0;
                  state  <= S_LO;
               end else begin
                  err <= 1'b1;
               end
            end
         end else if (cnt == lim) begin
            cnt <= '0;
            case (state)
               S_LO: state <= S_HI;
               S_HI: begin
                  shreg <= {shreg[WORD_W-2:0], 1'b0};
                  if (bit_i == 5'(WORD_W - 1)) begin
                     bit_i <= '0;
                     state <= S_PRE;
                  end else begin
                     bit_i <= bit_i + 5'd1;
                     state <= S_LO;
                  end
               end
               S_PRE: state <= S_LE;
               S_LE:  state <= S_GAP;
               S_GAP: begin
                  if (!second) begin
                     second <= 1'b1;
                     shreg  <= pend;
                     state  <= S_LO;
                  end else begin
                     state <= S_IDLE;
                     done  <= 1'b1;
                  end
               end
               default: state <= S_IDLE;
            endcase
         end else begin
            cnt <= cnt + CW'(1);
         end
      end
   end

   assign busy     = (state != S_IDLE);
   assign ser_clk  = (state == S_HI);
   assign ser_le   = (state == S_LE);
   assign ser_data = shreg[WORD_W-1];

endmodule

// File: rtl/synth_wire_loader.sv
`timescale 1ns/1ps
module synth_wire_loader #(
   parameter int CH_W      = 8,
   parameter int BASE_N    = 34904,
   parameter int REF_DIV   = 1700,
   parameter bit PRESC_SW  = 1'b1,
   parameter int CLK_PS    = 5000,
   parameter int T_DAT_PS  = 20000,
   parameter int T_EDGE_PS = 30000,
   parameter int T_LE_PS   = 100000
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   input  logic [CH_W-1:0] req_chan,
   output logic            busy,
   output logic            done,
   output logic            err,
   output logic            ser_clk,
   output logic            ser_data,
   output logic            ser_le
);
   import swl_pkg::*;

   localparam int HALF_CYC = ceil_cnt(T_DAT_PS, CLK_PS);
   localparam int EDGE_CYC = ceil_cnt(T_EDGE_PS, CLK_PS);
   localparam int LE_CYC   = ceil_cnt(T_LE_PS, CLK_PS);
   localparam int GAP_CYC  = (LE_CYC > EDGE_CYC) ? LE_CYC : EDGE_CYC;

   generate
      if (REF_DIV < 3 || REF_DIV > 16383) begin : g_bad_ref
         $error("REF_DIV out of 14-bit counter range");
      end
      if (CH_W < 1 || CH_W > 16) begin : g_bad_chw
         $error("CH_W out of range");
      end
      if (CLK_PS < 1) begin : g_bad_clk
         $error("CLK_PS must be positive");
      end
   endgenerate

   logic [10:0]       n_cnt;
   logic [6:0]        a_cnt;
   logic              ok;
   logic [WORD_W-1:0] ref_word;
   logic [WORD_W-1:0] cnt_word;

   swl_ratio_split #(.CH_W(CH_W), .BASE_N(BASE_N), .SW(PRESC_SW)) u_split (
      .chan  (req_chan),
      .n_cnt (n_cnt),
      .a_cnt (a_cnt),
      .ok    (ok)
   );

   swl_word_build #(.REF_DIV(REF_DIV), .SW(PRESC_SW)) u_build (
      .n_cnt    (n_cnt),
      .a_cnt    (a_cnt),
      .ref_word (ref_word),
      .cnt_word (cnt_word)
   );

   swl_serial_seq #(
      .HALF_CYC (HALF_CYC),
      .EDGE_CYC (EDGE_CYC),
      .LE_CYC   (LE_CYC),
      .GAP_CYC  (GAP_CYC)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (req_valid),
      .ok       (ok),
      .w_first  (ref_word),
      .w_second (cnt_word),
      .busy     (busy),
      .done     (done),
      .err      (err),
      .ser_clk  (ser_clk),
      .ser_data (ser_data),
      .ser_le   (ser_le)
   );

endmodule

// File: rtl/synth_wire_loader_chk.sv
`timescale 1ns/1ps
module synth_wire_loader_chk #(
   parameter int LE_CYC = 20
) (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic done,
   input logic err,
   input logic ser_clk,
   input logic ser_data,
   input logic ser_le
);
   logic [15:0] le_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      le_run <= '0;
      else if (ser_le) le_run <= le_run + 16'd1;
      else             le_run <= '0;
   end

   // R5
   le_quiet_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ser_clk |-> !ser_le);

   // R5
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

   // R6
   le_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ser_le) |-> (le_run == 16'(LE_CYC)));

   // R7
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R8
   busy_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !err);

   // R9
   err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (!busy && !ser_clk && !ser_le));

endmodule

bind synth_wire_loader synth_wire_loader_chk #(.LE_CYC(LE_CYC)) u_chk (.*);

// File: tb/synth_wire_loader_bench.sv
`timescale 1ns/1ps
module synth_wire_loader_bench;
   localparam int CLK_PS = 5000;
   localparam int HALF   = (20000 + CLK_PS - 1) / CLK_PS;
   localparam int EDGE   = (30000 + CLK_PS - 1) / CLK_PS;
   localparam int LEW    = (100000 + CLK_PS - 1) / CLK_PS;
   localparam int GAPC   = (LEW > EDGE) ? LEW : EDGE;
   localparam int WCYC   = 19 * 2 * HALF + EDGE + LEW + GAPC;
   localparam int BASE   = 34904;
   localparam int BASE2  = 190;
   localparam int RDIV   = 1700;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic       req = 1'b0, req2 = 1'b0;
   logic [7:0] ch = '0, ch2 = '0;
   logic busy, done, err, ser_clk, ser_data, ser_le;
   logic busy2, done2, err2, sclk2, sdat2, sle2;

   synth_wire_loader u_synth_wire_loader (
      .clk(clk), .rst_n(rst_n), .req_valid(req), .req_chan(ch),
      .busy(busy), .done(done), .err(err),
      .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le));

   synth_wire_loader #(.BASE_N(BASE2)) u_synth_wire_loader2 (
      .clk(clk), .rst_n(rst_n), .req_valid(req2), .req_chan(ch2),
      .busy(busy2), .done(done2), .err(err2),
      .ser_clk(sclk2), .ser_data(sdat2), .ser_le(sle2));

   int checks = 0, fails = 0;
   logic [5:0]  q[$];
   int          exp_ch = 0;
   int          widx = 0, nb = 0;
   logic [18:0] cap = '0;

   task automatic chk(input bit cond, input string rq, input int act, input int exp);
      checks++;
      if (!cond) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   function automatic logic [18:0] ref_w();
      return 19'((1 << 16) | (1 << 15) | (RDIV << 1) | 1);
   endfunction

   function automatic logic [18:0] cnt_w(input int base, input int c);
      int n = base + c;
      return 19'(((n / 64) << 8) | ((n % 64) << 1));
   endfunction

   function automatic bit valid_n(input int base, input int c);
      int n = base + c;
      return (n / 64 >= 3) && (n / 64 <= 2047) && (n % 64 < n / 64);
   endfunction

   // tuple order: busy, done, err, ser_clk, ser_data, ser_le
   task automatic push_word(input logic [18:0] w);
      for (int i = 18; i >= 0; i--) begin
         for (int k = 0; k < HALF; k++) q.push_back({3'b100, 1'b0, w[i], 1'b0});
         for (int k = 0; k < HALF; k++) q.push_back({3'b100, 1'b1, w[i], 1'b0});
      end
      for (int k = 0; k < EDGE; k++) q.push_back(6'b100000);
      for (int k = 0; k < LEW; k++)  q.push_back(6'b100001);
      for (int k = 0; k < GAPC; k++) q.push_back(6'b100000);
   endtask

   // Cycle reference model for the default instance
   always @(negedge clk) begin
      logic [5:0] e, a;
      string tag;
      if (rst_n) begin
         e = (q.size() > 0) ? q.pop_front() : 6'b000000;
         a = {busy, done, err, ser_clk, ser_data, ser_le};
         if (a[5] !== e[5] || a[4] !== e[4]) tag = "R7 busy/done";
         else if (a[3] !== e[3]) tag = "R9 err";
         else if (a[2] !== e[2]) tag = "R5 ser_clk";
         else if (a[1] !== e[1]) tag = "R4 ser_data";
         else tag = "R6 ser_le";
         chk(a === e, tag, int'(a), int'(e));
         if (!e[5] && req) begin
            if (valid_n(BASE, int'(ch))) begin
               exp_ch = int'(ch);
               push_word(ref_w());
               push_word(cnt_w(BASE, int'(ch)));
               q.push_back(6'b010000);
            end else begin
               q.push_back(6'b001000);
            end
         end
      end
   end

   // Word decoder on the serial pins of the default instance
   always @(posedge ser_clk or posedge ser_le or negedge rst_n) begin
      if (!rst_n) begin
         widx = 0; nb = 0;
      end else if (ser_le) begin
         chk(nb == 19, "R5 bits per word", nb, 19);
         if (widx == 0) chk(cap == ref_w(), "R3 R4 reference word first", int'(cap), int'(ref_w()));
         else chk(cap == cnt_w(BASE, exp_ch), "R1 R2 counter word", int'(cap), int'(cnt_w(BASE, exp_ch)));
         widx = 1 - widx;
         nb = 0;
      end else begin
         cap = {cap[17:0], ser_data};
         nb++;
      end
   end

   task automatic send(input int c);
      @(posedge clk); #1 req = 1'b1; ch = 8'(c);
      @(posedge clk); #1 req = 1'b0;
   endtask

   task automatic send2(input int c);
      @(posedge clk); #1 req2 = 1'b1; ch2 = 8'(c);
      @(posedge clk); #1 req2 = 1'b0;
   endtask

   task automatic wait_idle();
      do @(negedge clk); while (busy || q.size() > 0);
      repeat (2) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R10 reset values
      chk({busy, done, err, ser_clk, ser_data, ser_le} == 6'b0, "R10 reset outputs",
          int'({busy, done, err, ser_clk, ser_data, ser_le}), 0);
      chk({busy2, done2, err2, sclk2, sdat2, sle2} == 6'b0, "R10 reset outputs 2",
          int'({busy2, done2, err2, sclk2, sdat2, sle2}), 0);
      rst_n = 1'b1;

      send(0);                 // R1 N=545 A=24
      wait_idle();
      send(40);                // R1 N=546 A=0
      repeat (50) @(posedge clk);
      send(7);                 // R8 ignored while busy
      wait_idle();
      send(255);
      wait_idle();

      // R7 accept in the done cycle: hold request across transfers
      @(posedge clk); #1 req = 1'b1; ch = 8'd3;
      repeat (2 * WCYC + 20) @(posedge clk);
      #1 req = 1'b0;
      wait_idle();

      // R9 refusals on the small-base instance
      send2(0);                // n=190: N=2
      chk(err2 == 1'b1 && busy2 == 1'b0, "R9 err for N<3", int'({err2, busy2}), 2);
      @(posedge clk); #1;
      chk(err2 == 1'b0, "R9 err one cycle", int'(err2), 0);
      send2(5);                // n=195: N=3 A=3
      chk(err2 == 1'b1 && busy2 == 1'b0 && sclk2 == 1'b0, "R9 err for A>=N",
          int'({err2, busy2, sclk2}), 4);
      send2(2);                // n=192: N=3 A=0 valid
      chk(busy2 == 1'b1 && err2 == 1'b0, "R9 valid boundary accepted", int'({busy2, err2}), 2);
      repeat (2 * WCYC) @(posedge clk);
      #1;
      chk(done2 == 1'b1 && busy2 == 1'b0, "R7 done after two words", int'({done2, busy2}), 2);
      @(posedge clk); #1;
      chk(done2 == 1'b0, "R7 done single cycle", int'(done2), 0);

      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

endmodule